// File: doc/BRIEF.md
# Transceiver Bring-Up Reset Sequencer

This block is the user-side controller that takes a multi-lane serial transceiver channel from power-up to normal traffic. It holds every reset at power-up. It frees the register-bus reset once both of its clocks are reported good. It then frees the core reset when the user signals that configuration is complete, and waits for the calibration-done status. After that it brings each lane's transmitter out of electrical idle and then frees that lane's transmit and receive PCS resets in turn. Register write requests pass only while the sequencer is in a phase where writes are safe.

The clock-good, calibration-ready and receive-valid status inputs come from other clock domains. Each one passes through a two-flop synchronizer before the sequencer uses it. Each lane also carries a requested power-down code. The block cleans that code, drives it out, and only a lane in the operational code takes part in the bring-up. A calibration timeout sets a sticky error flag and sends the sequencer back to full reset.

The sequencer has four named states:

- **S_HOLD**: all resets are asserted.
- **S_CONFIG**: the register bus is live and the core is still in reset.
- **S_CAL**: the core has left reset and the sequencer waits for calibration.
- **S_RUN**: the per-lane bring-up runs.

The transitions are:

- **HOLD→CONFIG**: both synchronized clock-good inputs are high.
- **CONFIG→CAL**: `cfg_done` is high.
- **CAL→RUN**: every operational lane reports ready.
- **CAL→HOLD**: the timeout expires.
- **any→HOLD**: either clock-good input is low.

Top module: `xcvr_bringup_seq`

## Requirements
- R1: While `por_n` is low, the following hold: every reset output is low, `tx_valid` is zero, `wr_grant` is 0, `cal_err` is 0, and each lane's `pwr_code` is 2'b11.
- R2: `bus_rst_n` goes high only after both `bus_clk_ok` and `pcs_clk_ok` have been seen high through their synchronizers. If either of them drops, the sequencer returns to S_HOLD and all resets reassert.
- R3: `core_rst_n` goes high only in the cycle after S_CONFIG sees `cfg_done`. It is never high while `bus_rst_n` is low.
- R4: S_CAL moves to S_RUN only when every lane whose code is operational has its synchronized `pma_ready` bit high. Ready bits of non-operational lanes are ignored.
- R5: `wr_grant` equals `wr_req` in S_CONFIG and in S_RUN. It is 0 in S_HOLD and in S_CAL, which covers the whole window from core reset release until calibration is done.
- R6: In S_RUN, an operational lane with ready high gets `tx_valid` high. The lane's `tx_pcs_rst_n` goes high one cycle after its `tx_valid` rises, and never before.
- R7: In S_RUN, an operational lane's `rx_pcs_rst_n` goes high only while its synchronized `rx_valid` bit is high.
- R8: The power code for lane l sits at bits [2l+1:2l] of `pwr_code`. The codes are 2'b00 operational, 2'b10 low power and 2'b11 deep low power. A requested 2'b01 is driven as 2'b11, so 2'b01 never appears.
- R9: A lane whose driven code is not 2'b00 has `tx_valid`, `tx_pcs_rst_n` and `rx_pcs_rst_n` all low.
- R10: In S_RUN, if a lane's ready bit drops, that lane's `tx_valid` and `tx_pcs_rst_n` fall. If its receive-valid bit drops, its `rx_pcs_rst_n` falls. Each one recovers when its status bit returns.
- R11: If S_CAL lasts `CAL_TIMEOUT` cycles without calibration finishing, `cal_err` is set and the sequencer enters S_HOLD. `cal_err` then stays set until `por_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| bus_clk_ok | input | 1 | Register-bus clock valid (asynchronous) |
| pcs_clk_ok | input | 1 | PCS input clock valid (asynchronous) |
| cfg_done | input | 1 | User register configuration complete |
| pma_ready | input | LANES | Per-lane calibration done (asynchronous) |
| rx_valid | input | LANES | Per-lane CDR locked to data (asynchronous) |
| pwr_req | input | 2*LANES | Requested per-lane power-down code |
| wr_req | input | 1 | User register write request |
| bus_rst_n | output | 1 | Register-bus reset, active low |
| core_rst_n | output | 1 | PMA/controller core reset, active low |
| tx_pcs_rst_n | output | LANES | Per-lane transmit PCS reset, active low |
| rx_pcs_rst_n | output | LANES | Per-lane receive PCS reset, active low |
| tx_valid | output | LANES | Per-lane exit from electrical idle |
| pwr_code | output | 2*LANES | Driven per-lane power-down code |
| wr_grant | output | 1 | Gated register write request |
| cal_err | output | 1 | Sticky calibration timeout flag |

## Verification
The hardest situation to reach is the calibration timeout followed by recovery. The sequencer must sit in S_CAL for a full timeout window, go through S_HOLD, and come back with the error flag still set. The bench reaches it by restoring both clocks while every ready bit is low. It then drops `cfg_done` while the sequencer is in S_CAL, so that after the timeout the sequencer parks in S_CONFIG, where the error and reset levels can be sampled. Finally, it raises ready with one lane powered down, so the run that follows also shows that the powered-down lane's ready bit is ignored.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

    typedef enum logic [1:0] {
        S_HOLD   = 2'd0,
        S_CONFIG = 2'd1,
        S_CAL    = 2'd2,
        S_RUN    = 2'd3
    } seq_state_t;

    localparam logic [1:0] PD_OPER = 2'b00;
    localparam logic [1:0] PD_LOW  = 2'b10;
    localparam logic [1:0] PD_DEEP = 2'b11;

    // Map a requested code onto the three legal codes; 2'b01 becomes deep low power.
    function automatic logic [1:0] pd_clean(input logic [1:0] req);
        logic [1:0] res;
        unique case (req)
            PD_OPER: res = PD_OPER;
            PD_LOW:  res = PD_LOW;
            default: res = PD_DEEP;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/xbs_sync2.sv
module xbs_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;

endmodule

// File: rtl/xbs_cal_timer.sv
module xbs_cal_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/xbs_lane.sv
module xbs_lane
    import xbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       ready_s,
    input  logic       rxval_s,
    input  logic [1:0] pwr_req,
    output logic [1:0] pwr_code,
    output logic       active,
    output logic       tx_valid,
    output logic       tx_rst_n,
    output logic       rx_rst_n
);

    logic [1:0] pwr_q;
    logic       txv_q;
    logic       txr_q;
    logic       rxr_q;
    logic       tx_ok;

    assign active = (pwr_q == PD_OPER);
    assign tx_ok  = run && active && ready_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q <= PD_DEEP;
            txv_q <= 1'b0;
            txr_q <= 1'b0;
            rxr_q <= 1'b0;
        end else begin
            pwr_q <= pd_clean(pwr_req);
            txv_q <= tx_ok;
            txr_q <= tx_ok && txv_q;
            rxr_q <= run && active && rxval_s;
        end
    end

    assign pwr_code = pwr_q;
    assign tx_valid = txv_q;
    assign tx_rst_n = txr_q;
    assign rx_rst_n = rxr_q;

endmodule

// File: rtl/xcvr_bringup_seq.sv
module xcvr_bringup_seq
    import xbs_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int CAL_TIMEOUT = 100000
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               bus_clk_ok,
    input  logic               pcs_clk_ok,
    input  logic               cfg_done,
    input  logic [LANES-1:0]   pma_ready,
    input  logic [LANES-1:0]   rx_valid,
    input  logic [2*LANES-1:0] pwr_req,
    input  logic               wr_req,
    output logic               bus_rst_n,
    output logic               core_rst_n,
    output logic [LANES-1:0]   tx_pcs_rst_n,
    output logic [LANES-1:0]   rx_pcs_rst_n,
    output logic [LANES-1:0]   tx_valid,
    output logic [2*LANES-1:0] pwr_code,
    output logic               wr_grant,
    output logic               cal_err
);

    localparam int SW = 2 + 2 * LANES;

    seq_state_t       state_q;
    seq_state_t       state_d;
    logic [SW-1:0]    raw_status;
    logic [SW-1:0]    sync_status;
    logic             bus_ok_s;
    logic             pcs_ok_s;
    logic             clk_ok_s;
    logic [LANES-1:0] ready_s;
    logic [LANES-1:0] rxval_s;
    logic [LANES-1:0] lane_active;
    logic             cal_done;
    logic             cal_expired;
    logic             in_cal;
    logic             in_run;
    logic             err_q;

    // Status synchronizers
    assign raw_status = {rx_valid, pma_ready, pcs_clk_ok, bus_clk_ok};

    xbs_sync2 #(.W(SW)) status_sync_i (
        .clk   (clk),
        .rst_n (por_n),
        .d     (raw_status),
        .q     (sync_status)
    );

    assign bus_ok_s = sync_status[0];
    assign pcs_ok_s = sync_status[1];
    assign ready_s  = sync_status[2 +: LANES];
    assign rxval_s  = sync_status[2 + LANES +: LANES];
    assign clk_ok_s = bus_ok_s && pcs_ok_s;

    // Calibration done: every operational lane reports ready
    assign cal_done = &(ready_s | ~lane_active);

    xbs_cal_timer #(.LIMIT(CAL_TIMEOUT)) cal_timer_i (
        .clk     (clk),
        .rst_n   (por_n),
        .run     (in_cal),
        .expired (cal_expired)
    );

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= S_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HOLD: begin
                if (clk_ok_s) state_d = S_CONFIG;
            end
            S_CONFIG: begin
                if (!clk_ok_s)     state_d = S_HOLD;
                else if (cfg_done) state_d = S_CAL;
            end
            S_CAL: begin
                if (!clk_ok_s)        state_d = S_HOLD;
                else if (cal_done)    state_d = S_RUN;
                else if (cal_expired) state_d = S_HOLD;
            end
            S_RUN: begin
                if (!clk_ok_s) state_d = S_HOLD;
            end
        endcase
    end

    // Outputs derived from state
    always_comb begin
        bus_rst_n  = 1'b0;
        core_rst_n = 1'b0;
        in_cal     = 1'b0;
        in_run     = 1'b0;
        wr_grant   = 1'b0;
        unique case (state_q)
            S_HOLD: begin
            end
            S_CONFIG: begin
                bus_rst_n = 1'b1;
                wr_grant  = wr_req;
            end
            S_CAL: begin
                bus_rst_n  = 1'b1;
                core_rst_n = 1'b1;
                in_cal     = 1'b1;
            end
            S_RUN: begin
                bus_rst_n  = 1'b1;
                core_rst_n = 1'b1;
                in_run     = 1'b1;
                wr_grant   = wr_req;
            end
        endcase
    end

    // Sticky calibration error
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            err_q <= 1'b0;
        end else if (in_cal && !cal_done && cal_expired && clk_ok_s) begin
            err_q <= 1'b1;
        end
    end

    assign cal_err = err_q;

    // Per-lane bring-up
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        xbs_lane lane_i (
            .clk      (clk),
            .rst_n    (por_n),
            .run      (in_run),
            .ready_s  (ready_s[l]),
            .rxval_s  (rxval_s[l]),
            .pwr_req  (pwr_req[2*l +: 2]),
            .pwr_code (pwr_code[2*l +: 2]),
            .active   (lane_active[l]),
            .tx_valid (tx_valid[l]),
            .tx_rst_n (tx_pcs_rst_n[l]),
            .rx_rst_n (rx_pcs_rst_n[l])
        );
    end

endmodule

// File: rtl/xbs_checker.sv
module xbs_checker
    import xbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic               clk,
    input logic               por_n,
    input seq_state_t         state_q,
    input logic               clk_ok_s,
    input logic               cfg_done,
    input logic               bus_rst_n,
    input logic               core_rst_n,
    input logic [LANES-1:0]   tx_pcs_rst_n,
    input logic [LANES-1:0]   rx_pcs_rst_n,
    input logic [LANES-1:0]   tx_valid,
    input logic [2*LANES-1:0] pwr_code,
    input logic               wr_grant,
    input logic               cal_err
);

    p_bus_after_clocks_r2: assert property (@(posedge clk) disable iff (!por_n)
        $rose(bus_rst_n) |-> $past(clk_ok_s));

    p_core_after_cfg_r3: assert property (@(posedge clk) disable iff (!por_n)
        $rose(core_rst_n) |-> $past(cfg_done));

    p_core_needs_bus_r3: assert property (@(posedge clk) disable iff (!por_n)
        !bus_rst_n |-> !core_rst_n);

    p_no_write_in_cal_r5: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == S_CAL) |-> !wr_grant);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!por_n)
        cal_err |=> cal_err);

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        p_txrst_after_valid_r6: assert property (@(posedge clk) disable iff (!por_n)
            $rose(tx_pcs_rst_n[l]) |-> $past(tx_valid[l]));

        p_code_legal_r8: assert property (@(posedge clk) disable iff (!por_n)
            pwr_code[2*l +: 2] != 2'b01);

        p_inactive_quiet_r9: assert property (@(posedge clk) disable iff (!por_n)
            (pwr_code[2*l +: 2] != 2'b00) |=>
                (!tx_valid[l] && !tx_pcs_rst_n[l] && !rx_pcs_rst_n[l]));
    end

endmodule

bind xcvr_bringup_seq xbs_checker #(.LANES(LANES)) chk_i (
    .clk          (clk),
    .por_n        (por_n),
    .state_q      (state_q),
    .clk_ok_s     (clk_ok_s),
    .cfg_done     (cfg_done),
    .bus_rst_n    (bus_rst_n),
    .core_rst_n   (core_rst_n),
    .tx_pcs_rst_n (tx_pcs_rst_n),
    .rx_pcs_rst_n (rx_pcs_rst_n),
    .tx_valid     (tx_valid),
    .pwr_code     (pwr_code),
    .wr_grant     (wr_grant),
    .cal_err      (cal_err)
);

// File: tb/xcvr_bringup_seq_tb_top.sv
module xcvr_bringup_seq_tb_top;

    localparam int LANES = 2;
    localparam int CAL_TIMEOUT = 40;
    localparam int VW = 14;

    logic               clk = 1'b0;
    logic               por_n;
    logic               bus_clk_ok;
    logic               pcs_clk_ok;
    logic               cfg_done;
    logic [LANES-1:0]   pma_ready;
    logic [LANES-1:0]   rx_valid;
    logic [2*LANES-1:0] pwr_req;
    logic               wr_req;
    logic               bus_rst_n;
    logic               core_rst_n;
    logic [LANES-1:0]   tx_pcs_rst_n;
    logic [LANES-1:0]   rx_pcs_rst_n;
    logic [LANES-1:0]   tx_valid;
    logic [2*LANES-1:0] pwr_code;
    logic               wr_grant;
    logic               cal_err;

    typedef struct {
        logic [VW-1:0] v;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #4 clk = ~clk;

    xcvr_bringup_seq #(.LANES(LANES), .CAL_TIMEOUT(CAL_TIMEOUT)) dut_i (
        .clk          (clk),
        .por_n        (por_n),
        .bus_clk_ok   (bus_clk_ok),
        .pcs_clk_ok   (pcs_clk_ok),
        .cfg_done     (cfg_done),
        .pma_ready    (pma_ready),
        .rx_valid     (rx_valid),
        .pwr_req      (pwr_req),
        .wr_req       (wr_req),
        .bus_rst_n    (bus_rst_n),
        .core_rst_n   (core_rst_n),
        .tx_pcs_rst_n (tx_pcs_rst_n),
        .rx_pcs_rst_n (rx_pcs_rst_n),
        .tx_valid     (tx_valid),
        .pwr_code     (pwr_code),
        .wr_grant     (wr_grant),
        .cal_err      (cal_err)
    );

    // Driver side: push one expected snapshot, then hold inputs for a cycle
    task automatic expect_out(input string tag, input logic b, input logic c,
                              input logic [1:0] tv, input logic [1:0] tr,
                              input logic [1:0] rr, input logic [3:0] pw,
                              input logic wg, input logic er);
        exp_t e;
        e.v   = {b, c, tv, tr, rr, pw, wg, er};
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor side: pop and compare
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                logic [VW-1:0] act;
                e   = exp_q.pop_front();
                act = {bus_rst_n, core_rst_n, tx_valid, tx_pcs_rst_n, rx_pcs_rst_n,
                       pwr_code, wr_grant, cal_err};
                n_cmp++;
                if (act !== e.v) begin
                    n_fail++;
                    $display("FAIL %s: actual %b expected %b", e.tag, act, e.v);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    // Fields: bus core tv tr rr pw wg err
    initial begin
        por_n = 1'b0; bus_clk_ok = 1'b0; pcs_clk_ok = 1'b0; cfg_done = 1'b0;
        pma_ready = '0; rx_valid = '0; pwr_req = 4'b0000; wr_req = 1'b1;
        settle(3);
        expect_out("R1 reset state", 0, 0, 2'b00, 2'b00, 2'b00, 4'b1111, 0, 0);
        por_n = 1'b1;
        settle(8);
        expect_out("R2 no clocks held", 0, 0, 2'b00, 2'b00, 2'b00, 4'b0000, 0, 0);
        bus_clk_ok = 1'b1;
        settle(8);
        expect_out("R2 one clock only", 0, 0, 2'b00, 2'b00, 2'b00, 4'b0000, 0, 0);
        pcs_clk_ok = 1'b1;
        settle(8);
        expect_out("R5 config writes pass", 1, 0, 2'b00, 2'b00, 2'b00, 4'b0000, 1, 0);
        cfg_done = 1'b1;
        settle(8);
        expect_out("R3 core released, R5 blocked", 1, 1, 2'b00, 2'b00, 2'b00, 4'b0000, 0, 0);
        pma_ready = 2'b01;
        settle(8);
        expect_out("R4 partial ready stays in cal", 1, 1, 2'b00, 2'b00, 2'b00, 4'b0000, 0, 0);
        pma_ready = 2'b11;
        settle(8);
        expect_out("R6 run tx up", 1, 1, 2'b11, 2'b11, 2'b00, 4'b0000, 1, 0);
        wr_req = 1'b0;
        settle(2);
        expect_out("R5 grant follows req", 1, 1, 2'b11, 2'b11, 2'b00, 4'b0000, 0, 0);
        rx_valid = 2'b01;
        settle(8);
        expect_out("R7 rx lane0", 1, 1, 2'b11, 2'b11, 2'b01, 4'b0000, 0, 0);
        pma_ready = 2'b01;
        settle(8);
        expect_out("R10 ready drop lane1", 1, 1, 2'b01, 2'b01, 2'b01, 4'b0000, 0, 0);
        pma_ready = 2'b11;
        settle(8);
        expect_out("R10 ready back lane1", 1, 1, 2'b11, 2'b11, 2'b01, 4'b0000, 0, 0);
        rx_valid = 2'b00;
        settle(8);
        expect_out("R10 rx drop lane0", 1, 1, 2'b11, 2'b11, 2'b00, 4'b0000, 0, 0);
        rx_valid = 2'b11;
        settle(8);
        expect_out("R7 rx both", 1, 1, 2'b11, 2'b11, 2'b11, 4'b0000, 0, 0);
        pwr_req = 4'b1000;
        settle(8);
        expect_out("R9 lane1 low power", 1, 1, 2'b01, 2'b01, 2'b01, 4'b1000, 0, 0);
        pwr_req = 4'b0100;
        settle(8);
        expect_out("R8 code 01 driven as 11", 1, 1, 2'b01, 2'b01, 2'b01, 4'b1100, 0, 0);
        pwr_req = 4'b0000;
        settle(8);
        expect_out("R9 lane1 restored", 1, 1, 2'b11, 2'b11, 2'b11, 4'b0000, 0, 0);
        wr_req = 1'b1;
        pcs_clk_ok = 1'b0;
        settle(8);
        expect_out("R2 clock loss full reset", 0, 0, 2'b00, 2'b00, 2'b00, 4'b0000, 0, 0);
        pma_ready = 2'b00; rx_valid = 2'b00;
        pcs_clk_ok = 1'b1;
        settle(8);
        expect_out("R11 in cal before timeout", 1, 1, 2'b00, 2'b00, 2'b00, 4'b0000, 0, 0);
        cfg_done = 1'b0;
        settle(CAL_TIMEOUT + 8);
        expect_out("R11 timeout error", 1, 0, 2'b00, 2'b00, 2'b00, 4'b0000, 1, 1);
        pwr_req = 4'b1100;
        pma_ready = 2'b01;
        cfg_done = 1'b1;
        settle(10);
        expect_out("R4 inactive lane ignored, R11 sticky", 1, 1, 2'b01, 2'b01, 2'b00, 4'b1100, 1, 1);
        settle(4);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule